// File: doc/BRIEF.md
# Output Fault Retry and Qualification Timer

This block times the fault handling for one protected power output. While the output is driven normally and the short comparator fires, the gate is dropped. The block then runs a retry loop on its own. A long refresh window holds the gate off, and a short retry window turns the gate back on so that the analog stage can test in current limit whether the short is still there. The loop ends at the first retry window that closes with the short flag clear. After that the output stays on.

Two open-load qualifiers run beside the loop. One runs while the output is commanded off and one while it is driven on normally, and each has its own qualification length. A fault bit becomes valid only once its comparator flag has been held for the whole length. All windows count a 1 µs tick enable.

The block takes the chip-select line of the serial port. A falling edge copies the pending fault bits into the reported register. A rising edge adopts the commanded output state that the serial shifter presents. Window lengths are parameters, and each is checked at elaboration against its allowed range: retry 25..100, refresh 3000..6000, off qualification 1..100, on qualification 1..12000.

Top module: `ofault_timer`

## Requirements
- R1: While reset is held, and after it, `gate_en` and all three fault outputs are 0.
- R2: `cmd_req` is adopted only at a rising edge of `cs_n`. The gate follows it two clock edges later and does not move while `cs_n` stays low.
- R3: When the short flag is seen while the output is on normally, `gate_en` falls at the next clock edge and stays low for exactly REFRESH_US ticks.
- R4: Each retry window holds `gate_en` high for exactly RETRY_US ticks. While the short persists, refresh and retry alternate, giving an on-duty of RETRY_US/(RETRY_US+REFRESH_US).
- R5: If the short flag is clear when a retry window ends, the gate stays high from then on.
- R6: `flt_short` reports 1 at the first chip-select sample after a short was seen, even if the short has since cleared. It reports 0 at the next sample after the loop has ended.
- R7: With the output commanded off, `flt_open_off` is reported only after `open_flag` has been held for OL_OFF_US consecutive ticks. A shorter run, or two runs split by a drop of the flag, are not reported.
- R8: With the output on normally, `flt_open_on` is reported only after `open_flag` has been held for OL_ON_US consecutive ticks. A drop of the flag restarts the count.
- R9: Commanding the output off aborts the retry loop at once. A later command on turns the gate on two edges after the chip-select rise, without waiting out a refresh.
- R10: The fault outputs change only at a falling edge of `cs_n`. A fault that qualifies while `cs_n` is high does not appear on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_us | input | 1 | One-cycle enable every microsecond |
| cs_n | input | 1 | Serial chip select, active low |
| cmd_req | input | 1 | Commanded output state from the serial shifter, 1 = on |
| short_flag | input | 1 | Short comparator flag |
| open_flag | input | 1 | Open-load comparator flag |
| gate_en | output | 1 | Gate drive enable |
| flt_short | output | 1 | Reported short fault bit |
| flt_open_off | output | 1 | Reported open-load fault, found with the output off |
| flt_open_on | output | 1 | Reported open-load fault, found with the output on |

## Verification
The bench builds the block with RETRY_US=25, REFRESH_US=3000, OL_OFF_US=60 and OL_ON_US=300, and drives the tick on every clock. One microsecond therefore equals one cycle. Both loop windows are the shortest legal values. This puts several full refresh and retry periods, measured to the exact cycle, within a short run. The reduced on-state qualification length lets the bench probe both qualifiers one tick below and a few ticks above their thresholds, and also split runs whose total exceeds the threshold.

// File: rtl/ofault_pkg.sv
// Package: shared state encoding for the output fault timer.
// Assumes nothing beyond a synthesizable enum.
package ofault_pkg;
    typedef enum logic [1:0] {
        SR_OFF     = 2'd0,
        SR_ON      = 2'd1,
        SR_REFRESH = 2'd2,
        SR_RETRY   = 2'd3
    } sr_state_t;
endpackage

// File: rtl/ofault_retry.sv
// Module: short-fault retry sequencer.
// Drives the gate. On a short it alternates a refresh window (gate off) and a
// retry window (gate on). It leaves the loop when a retry window ends with no
// short present. Assumes tick is a single-cycle enable and REFRESH_T > RETRY_T.
module ofault_retry
    import ofault_pkg::*;
#(
    parameter int RETRY_T   = 25,
    parameter int REFRESH_T = 4500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cmd_on,
    input  logic short_flag,
    output logic gate_en,
    output logic in_loop,
    output logic on_normal,
    output logic short_evt
);
    localparam int CW = $clog2(REFRESH_T + 1);

    sr_state_t       st, st_nxt;
    logic [CW-1:0]   cnt, cnt_nxt;

    // Next-state and window counter logic.
    always_comb begin
        st_nxt    = st;
        cnt_nxt   = cnt;
        short_evt = 1'b0;
        case (st)
            SR_OFF: if (cmd_on) st_nxt = SR_ON;
            SR_ON: if (short_flag) begin
                st_nxt    = SR_REFRESH;
                cnt_nxt   = '0;
                short_evt = 1'b1;
            end
            SR_REFRESH: if (tick) begin
                if (cnt == CW'(REFRESH_T - 1)) begin
                    st_nxt  = SR_RETRY;
                    cnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            SR_RETRY: if (tick) begin
                if (cnt == CW'(RETRY_T - 1)) begin
                    cnt_nxt = '0;
                    if (short_flag) begin
                        st_nxt    = SR_REFRESH;
                        short_evt = 1'b1;
                    end else begin
                        st_nxt = SR_ON;
                    end
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            default: st_nxt = SR_OFF;
        endcase
        if (!cmd_on) begin
            st_nxt    = SR_OFF;
            cnt_nxt   = '0;
            short_evt = 1'b0;
        end
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SR_OFF;
            cnt <= '0;
        end else begin
            st  <= st_nxt;
            cnt <= cnt_nxt;
        end
    end

    assign gate_en   = (st == SR_ON) || (st == SR_RETRY);
    assign in_loop   = (st == SR_REFRESH) || (st == SR_RETRY);
    assign on_normal = (st == SR_ON);

    AST_SHORT_DROPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SR_ON && short_flag && cmd_on) |=> !gate_en); // R3
    AST_RETRY_AFTER_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SR_RETRY && $past(st) != SR_RETRY) |-> $past(st) == SR_REFRESH); // R4
    AST_RETRY_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SR_RETRY) |-> cnt < CW'(RETRY_T)); // R4
    AST_REFRESH_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st == SR_REFRESH) |-> cnt < CW'(REFRESH_T)); // R3
endmodule

// File: rtl/ofault_qual.sv
// Module: open-load qualifier.
// Raises qual once flag has been held with enable for LEN consecutive ticks.
// Any drop of flag or enable restarts the count. Assumes LEN >= 1.
module ofault_qual #(
    parameter int LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enable,
    input  logic flag,
    output logic qual
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    // Count held ticks and flag qualification.
    always_ff @(posedge clk) begin
        if (!rst_n || !(enable && flag)) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (tick && !qual) begin
            if (cnt == CW'(LEN - 1)) qual <= 1'b1;
            else                     cnt  <= cnt + 1'b1;
        end
    end

    AST_QUAL_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> $past(enable && flag)); // R7
    AST_QUAL_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(LEN)); // R8
endmodule

// File: rtl/ofault_latch.sv
// Module: fault pending bits and reported register.
// Each bit holds a sticky pending flag. On a sample pulse the reported bit
// takes the pending value, and pending drops to the live condition. Assumes
// sample is a single-cycle pulse.
module ofault_latch #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic [W-1:0] set,
    input  logic [W-1:0] live,
    output logic [W-1:0] q
);
    logic [W-1:0] pend;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Pending capture and sample transfer for one fault bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[i] <= 1'b0;
                q[i]    <= 1'b0;
            end else if (sample) begin
                q[i]    <= pend[i];
                pend[i] <= set[i] | live[i];
            end else begin
                pend[i] <= pend[i] | set[i];
            end
        end

        AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !sample |=> $stable(q[i])); // R10
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (pend[i] && !sample) |=> pend[i]); // R6
    end
endmodule

// File: rtl/ofault_timer.sv
// Module: top of the output fault retry and qualification timer.
// Detects chip-select edges: a rise adopts the command, a fall samples the
// faults. Wires the retry sequencer, two open-load qualifiers and the fault
// register. Assumes cs_n and cmd_req are synchronous to clk.
module ofault_timer #(
    parameter int RETRY_US   = 50,
    parameter int REFRESH_US = 4500,
    parameter int OL_OFF_US  = 100,
    parameter int OL_ON_US   = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic cs_n,
    input  logic cmd_req,
    input  logic short_flag,
    input  logic open_flag,
    output logic gate_en,
    output logic flt_short,
    output logic flt_open_off,
    output logic flt_open_on
);
    if (RETRY_US < 25 || RETRY_US > 100) begin : g_bad_retry
        $error("RETRY_US outside 25..100");
    end
    if (REFRESH_US < 3000 || REFRESH_US > 6000) begin : g_bad_refresh
        $error("REFRESH_US outside 3000..6000");
    end
    if (OL_OFF_US < 1 || OL_OFF_US > 100) begin : g_bad_ol_off
        $error("OL_OFF_US outside 1..100");
    end
    if (OL_ON_US < 1 || OL_ON_US > 12000) begin : g_bad_ol_on
        $error("OL_ON_US outside 1..12000");
    end

    logic cs_q, cmd_q, cs_fall, cs_rise;
    logic in_loop, on_normal, short_evt, qual_off, qual_on;
    logic [2:0] fq;

    assign cs_fall = cs_q & ~cs_n;
    assign cs_rise = ~cs_q & cs_n;

    // Chip-select history and command adoption on its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            cmd_q <= 1'b0;
        end else begin
            cs_q <= cs_n;
            if (cs_rise) cmd_q <= cmd_req;
        end
    end

    ofault_retry #(.RETRY_T(RETRY_US), .REFRESH_T(REFRESH_US)) retry_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .cmd_on(cmd_q),
        .short_flag(short_flag), .gate_en(gate_en), .in_loop(in_loop),
        .on_normal(on_normal), .short_evt(short_evt)
    );

    ofault_qual #(.LEN(OL_OFF_US)) qual_off_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .enable(!cmd_q && !gate_en),
        .flag(open_flag), .qual(qual_off)
    );

    ofault_qual #(.LEN(OL_ON_US)) qual_on_i (
        .clk(clk), .rst_n(rst_n), .tick(tick_us), .enable(on_normal),
        .flag(open_flag), .qual(qual_on)
    );

    ofault_latch #(.W(3)) latch_i (
        .clk(clk), .rst_n(rst_n), .sample(cs_fall),
        .set({short_evt, qual_off, qual_on}),
        .live({in_loop, qual_off, qual_on}),
        .q(fq)
    );

    assign flt_short    = fq[2];
    assign flt_open_off = fq[1];
    assign flt_open_on  = fq[0];

    AST_CMD_OFF_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_q |=> !gate_en); // R9
    AST_CMD_HELD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rise |=> $stable(cmd_q)); // R2
endmodule

// File: tb/ofault_timer_tb_top.sv
module ofault_timer_tb_top;
    localparam int RT  = 25;
    localparam int RF  = 3000;
    localparam int OLF = 60;
    localparam int OLN = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b1;
    logic cs_n = 1'b1;
    logic cmd_req = 1'b0;
    logic short_flag = 1'b0;
    logic open_flag = 1'b0;
    logic gate_en, flt_short, flt_open_off, flt_open_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic s_short, s_ooff, s_oon;

    always #4 clk = ~clk;

    ofault_timer #(.RETRY_US(RT), .REFRESH_US(RF), .OL_OFF_US(OLF), .OL_ON_US(OLN)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cs_n(cs_n), .cmd_req(cmd_req),
        .short_flag(short_flag), .open_flag(open_flag), .gate_en(gate_en),
        .flt_short(flt_short), .flt_open_off(flt_open_off), .flt_open_on(flt_open_on)
    );

    // mode (1 = output on, 0 = off), first run, gap, second run, expected bit
    localparam int NV = 7;
    localparam int VEC [NV][5] = '{
        '{1, 299, 0, 0,   0},
        '{1, 310, 0, 0,   1},
        '{1, 200, 1, 200, 0},
        '{0, 59,  0, 0,   0},
        '{0, 65,  0, 0,   1},
        '{0, 40,  2, 40,  0},
        '{0, 500, 0, 0,   1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cs_pulse(input logic cmd);
        @(negedge clk);
        cs_n = 1'b0;
        cmd_req = cmd;
        repeat (2) @(negedge clk);
        s_short = flt_short;
        s_ooff = flt_open_off;
        s_oon = flt_open_on;
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_len(input logic val, output int n);
        n = 0;
        while (gate_en == val && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n, h, l, cur, prev;
        bit held;
        repeat (3) @(negedge clk);
        check(gate_en == 0 && flt_short == 0 && flt_open_off == 0 && flt_open_on == 0,
              "R1 in reset", gate_en, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({gate_en, flt_short, flt_open_off, flt_open_on} == 4'b0, "R1 after reset",
              {gate_en, flt_short, flt_open_off, flt_open_on}, 0);

        // R2: command held while cs_n low has no effect
        cs_n = 1'b0;
        cmd_req = 1'b1;
        repeat (3) @(negedge clk);
        check(gate_en == 0, "R2 cs low", gate_en, 0);
        cs_n = 1'b1;
        @(negedge clk);
        check(gate_en == 0, "R2 one edge after rise", gate_en, 0);
        @(negedge clk);
        check(gate_en == 1, "R2 two edges after rise", gate_en, 1);
        cur = 1;

        // Open-load table (R7, R8) with register hold check (R10)
        prev = 0;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][0] != cur) begin
                cur = VEC[i][0];
                cs_pulse(cur[0]);
                cs_pulse(cur[0]);
                prev = 0;
            end
            @(negedge clk);
            open_flag = 1'b1;
            repeat (VEC[i][1]) @(negedge clk);
            open_flag = 1'b0;
            if (VEC[i][2] != 0) begin
                repeat (VEC[i][2]) @(negedge clk);
                open_flag = 1'b1;
                repeat (VEC[i][3]) @(negedge clk);
                open_flag = 1'b0;
            end
            repeat (2) @(negedge clk);
            n = cur ? flt_open_on : flt_open_off;
            check(n == prev, "R10 hold before sample", n, prev);
            cs_pulse(cur[0]);
            n = cur ? s_oon : s_ooff;
            check(n == VEC[i][4], cur ? "R8 open on" : "R7 open off", n, VEC[i][4]);
            prev = n;
        end

        // Clear state and command on
        cs_pulse(1'b1);
        cs_pulse(1'b1);
        check(gate_en == 1, "R2 on again", gate_en, 1);

        // R3 / R4: retry loop timing
        @(negedge clk);
        short_flag = 1'b1;
        @(negedge clk);
        check(gate_en == 0, "R3 gate drops", gate_en, 0);
        run_len(1'b0, l);
        check(l == RF, "R3 refresh length", l, RF);
        run_len(1'b1, h);
        check(h == RT, "R4 retry length", h, RT);
        run_len(1'b0, l);
        check(l == RF, "R4 second refresh", l, RF);
        check(h * 10000 / (h + l) == RT * 10000 / (RT + RF), "R4 duty x1e4",
              h * 10000 / (h + l), RT * 10000 / (RT + RF));
        cs_pulse(1'b1);
        check(s_short == 1, "R6 short reported", s_short, 1);

        // R5: short clears during refresh
        run_len(1'b1, n);
        short_flag = 1'b0;
        run_len(1'b0, n);
        held = 1'b1;
        repeat (RT + 20) begin
            @(negedge clk);
            if (gate_en != 1) held = 1'b0;
        end
        check(held, "R5 stays on", held, 1);
        cs_pulse(1'b1);
        check(s_short == 1, "R6 kept until sampled", s_short, 1);
        cs_pulse(1'b1);
        check(s_short == 0, "R6 cleared after sample", s_short, 0);

        // R9: abort and restart
        @(negedge clk);
        short_flag = 1'b1;
        repeat (10) @(negedge clk);
        short_flag = 1'b0;
        cs_pulse(1'b0);
        check(gate_en == 0, "R9 aborted off", gate_en, 0);
        cs_pulse(1'b1);
        check(gate_en == 1, "R9 on without refresh", gate_en, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule